// File: doc/BRIEF.md
# ISA to host-port bridge

This block sits between an 8-bit ISA I/O slave decode and the 8-bit host parallel port of a DSP. An ISA I/O write that lands in an eight-port window is turned into one write access on the host port. The low three address bits choose which of the three host-port registers is written and which half of its 16-bit word is carried. The ISA data byte is placed on the host-port data lines. The block then drives a single active-low data strobe. Before the strobe falls and after it rises, the select, byte and data lines are held steady.

A second I/O port drives a register that holds the DSP in reset or lets it run. Software can therefore reset the DSP, load a program through the host port and release it, all without a power cycle. Only writes are supported. The host port's direction line is held at "write", its address strobe is held inactive, its chip select is held active and its second data strobe is held high.

The ISA strobe is brought into the clock domain through a synchronizer. The address, data and AEN lines are expected to be stable while the ISA write strobe is low, which is the normal ISA write timing.

Top module: `isa_hp_bridge`

## Requirements
- R1: Within a few clocks of reset release, the data strobe is high, the DSP reset output is low (DSP held), the register select, byte identify and data outputs are all zero, and the tied lines are fixed: direction low (write), address strobe high, chip select low, second data strobe high.
- R2: An ISA write with AEN low to ports 0x230, 0x231, 0x234, 0x235, 0x236 or 0x237 produces exactly one strobe pulse. During the pulse the register select equals address bits 2:1 (00 control, 10 address, 11 data), the byte identify equals address bit 0 (0 first/high byte, 1 second/low byte), and the data equals the ISA data byte.
- R3: Writes to ports 0x232 and 0x233 (address bits 2:1 = 01) produce no strobe.
- R4: A write with AEN high has no effect. It produces no strobe and leaves the DSP reset output unchanged, even at the reset port.
- R5: Writes outside the window and the reset port (for example 0x22F, 0x238, 0x241, 0x330) produce no strobe and leave the DSP reset output unchanged.
- R6: With default parameters, the strobe falls on the fourth rising clock edge, counting the first edge that samples the ISA write strobe low. It stays low for exactly two clocks.
- R7: The register select, byte identify and data outputs hold the same value for at least one clock before the strobe falls and for at least one clock after it rises.
- R8: Each ISA write gives at most one strobe pulse, however long the ISA write strobe stays low.
- R9: A write with AEN low to port 0x240 copies data bit 0 to the DSP reset output (0 holds the DSP in reset, 1 releases it). Bits 7:1 are ignored. The value is kept until the next such write, and the write produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isa_addr_i | input | 10 | ISA address lines 9:0 |
| isa_data_i | input | 8 | ISA data byte |
| isa_iow_n_i | input | 1 | ISA I/O write strobe, active low |
| isa_aen_i | input | 1 | ISA address enable, high during DMA cycles |
| hp_data_o | output | 8 | Host-port data byte |
| hp_regsel_o | output | 2 | Host-port register select |
| hp_half_o | output | 1 | Host-port byte identify (0 first byte, 1 second byte) |
| hp_rw_o | output | 1 | Host-port direction, tied to write (0) |
| hp_as_n_o | output | 1 | Host-port address strobe, tied inactive (1) |
| hp_cs_n_o | output | 1 | Host-port chip select, tied active (0) |
| hp_strobe_n_o | output | 1 | Host-port data strobe, active low |
| hp_strobe_alt_n_o | output | 1 | Second host-port data strobe, tied high |
| dsp_rst_n_o | output | 1 | DSP reset, active low |

## Verification
If the sequencer state is wrong, the strobe shows it at once. The pulse may fall early, late or twice, or it may be too wide or too narrow. The bench times every falling edge against the ISA write that caused it, to the exact clock, and measures every pulse width. If the captured control register is wrong, the DSP would latch bad select, byte or data values. Every pulse is compared against the expected item taken from a queue, and the bench samples the lines one clock before the fall and one clock after the rise. A wrong decode or a wrong reset-latch state shows up as an extra or missing pulse, or as a changed DSP reset level, within the ten or so clocks that follow the write.

// File: rtl/isa_hp_pkg.sv
package isa_hp_pkg;

  // Host-port register select; encoding is decoded by the DSP port.
  typedef enum logic [1:0] {
    HP_SEL_CTRL = 2'b00,
    HP_SEL_RSVD = 2'b01,
    HP_SEL_ADDR = 2'b10,
    HP_SEL_DATA = 2'b11
  } hp_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_STROBE,
    SQ_HOLD
  } sq_state_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       half;
  } hp_ctl_t;

endpackage

// File: rtl/isa_hp_sync.sv
module isa_hp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic iow_n_i,
  output logic wr_edge_o
);

  // chain[0..STAGES-1] synchronize, chain[STAGES] keeps the prior value
  logic [STAGES:0] chain;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= iow_n_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign wr_edge_o = !chain[STAGES-1] && chain[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_edge_o |=> !wr_edge_o); // R8

endmodule

// File: rtl/isa_hp_decode.sv
module isa_hp_decode
  import isa_hp_pkg::*;
#(
  parameter int            AW       = 10,
  parameter logic [AW-1:0] WIN_BASE = 10'h230,
  parameter logic [AW-1:0] RST_PORT = 10'h240
) (
  input  logic [AW-1:0] addr_i,
  input  logic          aen_i,
  output logic          hit_hp_o,
  output logic          hit_rst_o,
  output hp_ctl_t       ctl_o
);

  localparam int LOW_BITS = 3;

  logic in_window;
  logic rsvd_slot;

  always_comb begin
    in_window = (addr_i[AW-1:LOW_BITS] == WIN_BASE[AW-1:LOW_BITS]);
    rsvd_slot = (addr_i[2:1] == HP_SEL_RSVD);
    hit_hp_o  = !aen_i && in_window && !rsvd_slot;
    hit_rst_o = !aen_i && (addr_i == RST_PORT);
    ctl_o.sel  = addr_i[2:1];
    ctl_o.half = addr_i[0];
  end

endmodule

// File: rtl/isa_hp_seq.sv
module isa_hp_seq
  import isa_hp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SETUP_CLKS  = 1,
  parameter int STROBE_CLKS = 2,
  parameter int HOLD_CLKS   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  hp_ctl_t       ctl_i,
  input  logic [DW-1:0] data_i,
  output hp_ctl_t       ctl_o,
  output logic [DW-1:0] data_o,
  output logic          strobe_n_o,
  output logic          busy_o
);

  localparam int MAXC1 = (SETUP_CLKS > STROBE_CLKS) ? SETUP_CLKS : STROBE_CLKS;
  localparam int MAXC  = (MAXC1 > HOLD_CLKS) ? MAXC1 : HOLD_CLKS;
  localparam int CW    = $clog2(MAXC + 1);

  sq_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  hp_ctl_t       ctl_q;
  logic [DW-1:0] data_q;
  logic          strobe_n_q;
  logic          load;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          state_d = SQ_SETUP;
          cnt_d   = CW'(SETUP_CLKS - 1);
        end
      end
      SQ_SETUP: begin
        if (cnt_q == '0) begin
          state_d = SQ_STROBE;
          cnt_d   = CW'(STROBE_CLKS - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_STROBE: begin
        if (cnt_q == '0) begin
          state_d = SQ_HOLD;
          cnt_d   = CW'(HOLD_CLKS - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_HOLD: begin
        if (cnt_q == '0) state_d = SQ_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // state and strobe registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cnt_q      <= '0;
      strobe_n_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      strobe_n_q <= (state_d != SQ_STROBE);
    end
  end

  // captured controls, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      ctl_q  <= ctl_i;
      data_q <= data_i;
    end
  end

  assign ctl_o      = ctl_q;
  assign data_o     = data_q;
  assign strobe_n_o = strobe_n_q;
  assign busy_o     = (state_q != SQ_IDLE);

  // width counter for the strobe-width check
  logic [CW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (!strobe_n_q) low_run <= low_run + 1'b1;
    else                 low_run <= '0;
  end

  AST_CTL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n_o) |-> ($stable(ctl_o) && $stable(data_o))); // R7

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n_o) |=> ($stable(ctl_o) && $stable(data_o))); // R7

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n_o) |-> (low_run == CW'(STROBE_CLKS))); // R6

  AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(ctl_o) || $past(state_q) == SQ_HOLD)); // R8

endmodule

// File: rtl/isa_hp_rstlatch.sv
module isa_hp_rstlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic dsp_rst_n_o
);

  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (wr_en_i) hold_d = wr_bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign dsp_rst_n_o = hold_q;

  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(dsp_rst_n_o)); // R9

endmodule

// File: rtl/isa_hp_bridge.sv
module isa_hp_bridge
  import isa_hp_pkg::*;
#(
  parameter int            AW          = 10,
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter int            SETUP_CLKS  = 1,
  parameter int            STROBE_CLKS = 2,
  parameter int            HOLD_CLKS   = 1,
  parameter logic [AW-1:0] WIN_BASE    = 10'h230,
  parameter logic [AW-1:0] RST_PORT    = 10'h240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] isa_addr_i,
  input  logic [DW-1:0] isa_data_i,
  input  logic          isa_iow_n_i,
  input  logic          isa_aen_i,
  output logic [DW-1:0] hp_data_o,
  output logic [1:0]    hp_regsel_o,
  output logic          hp_half_o,
  output logic          hp_rw_o,
  output logic          hp_as_n_o,
  output logic          hp_cs_n_o,
  output logic          hp_strobe_n_o,
  output logic          hp_strobe_alt_n_o,
  output logic          dsp_rst_n_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic    wr_edge;
  logic    hit_hp, hit_rst;
  hp_ctl_t dec_ctl, seq_ctl;
  logic    busy;
  logic    start;

  isa_hp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .iow_n_i  (isa_iow_n_i),
    .wr_edge_o(wr_edge)
  );

  isa_hp_decode #(.AW(AW), .WIN_BASE(WIN_BASE), .RST_PORT(RST_PORT)) u_decode (
    .addr_i   (isa_addr_i),
    .aen_i    (isa_aen_i),
    .hit_hp_o (hit_hp),
    .hit_rst_o(hit_rst),
    .ctl_o    (dec_ctl)
  );

  assign start = wr_edge && hit_hp && !busy;

  isa_hp_seq #(
    .DW(DW), .SETUP_CLKS(SETUP_CLKS), .STROBE_CLKS(STROBE_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start),
    .ctl_i     (dec_ctl),
    .data_i    (isa_data_i),
    .ctl_o     (seq_ctl),
    .data_o    (hp_data_o),
    .strobe_n_o(hp_strobe_n_o),
    .busy_o    (busy)
  );

  isa_hp_rstlatch u_rstlatch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en_i    (wr_edge && hit_rst),
    .wr_bit_i   (isa_data_i[0]),
    .dsp_rst_n_o(dsp_rst_n_o)
  );

  assign hp_regsel_o       = seq_ctl.sel;
  assign hp_half_o         = seq_ctl.half;
  assign hp_rw_o           = 1'b0;
  assign hp_as_n_o         = 1'b1;
  assign hp_cs_n_o         = 1'b0;
  assign hp_strobe_alt_n_o = 1'b1;

  AST_DMA_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_edge && isa_aen_i) |=> $stable(dsp_rst_n_o)); // R4

  AST_RST_PORT_BIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_edge && hit_rst) |=> (dsp_rst_n_o == $past(isa_data_i[0]))); // R9

  AST_STROBE_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !hp_strobe_n_o |-> (hp_regsel_o != HP_SEL_RSVD)); // R3

endmodule

// File: tb/isa_hp_bridge_bench.sv
`timescale 1ns/1ps
module isa_hp_bridge_bench;

  localparam int LAT    = 4;   // R6: fall on 4th edge counting first low sample
  localparam int WIDTH  = 2;   // R6: strobe low clocks
  localparam int GAP    = 8;

  typedef struct {
    logic [1:0] sel;
    logic       half;
    logic [7:0] data;
    int         due;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] isa_addr;
  logic [7:0] isa_data;
  logic       isa_iow_n;
  logic       isa_aen;
  logic [7:0] hp_data;
  logic [1:0] hp_regsel;
  logic       hp_half, hp_rw, hp_as_n, hp_cs_n, hp_strobe_n, hp_strobe_alt_n, dsp_rst_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int falls = 0;
  exp_t sb_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  isa_hp_bridge u_isa_hp_bridge (
    .clk(clk), .rst_n(rst_n),
    .isa_addr_i(isa_addr), .isa_data_i(isa_data),
    .isa_iow_n_i(isa_iow_n), .isa_aen_i(isa_aen),
    .hp_data_o(hp_data), .hp_regsel_o(hp_regsel), .hp_half_o(hp_half),
    .hp_rw_o(hp_rw), .hp_as_n_o(hp_as_n), .hp_cs_n_o(hp_cs_n),
    .hp_strobe_n_o(hp_strobe_n), .hp_strobe_alt_n_o(hp_strobe_alt_n),
    .dsp_rst_n_o(dsp_rst_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one ISA write; pushes the expected strobe item when one is due
  task automatic isa_write(input logic [9:0] a, input logic [7:0] d,
                           input logic aen, input int hold, input bit expect_strobe);
    int t0;
    @(negedge clk);
    isa_addr = a; isa_data = d; isa_aen = aen;
    @(negedge clk);
    isa_iow_n = 1'b0;
    t0 = cyc;
    if (expect_strobe) sb_q.push_back('{sel: a[2:1], half: a[0], data: d, due: t0 + LAT});
    repeat (hold) @(negedge clk);
    isa_iow_n = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  // monitor: pops expected items at each strobe fall
  logic       m_prev_strobe = 1'b1;
  logic [1:0] m_prev_sel;
  logic       m_prev_half;
  logic [7:0] m_prev_data;
  int         m_low = 0;
  bit         m_hold_chk = 1'b0;
  logic [10:0] m_rise_val;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (m_hold_chk) begin
        chk({hp_regsel, hp_half, hp_data} == m_rise_val, "R7 hold after rise",
            {hp_regsel, hp_half, hp_data}, m_rise_val);
        m_hold_chk = 1'b0;
      end
      if (m_prev_strobe && !hp_strobe_n) begin
        exp_t e;
        falls++;
        m_low = 1;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2 unexpected strobe", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk(hp_regsel == e.sel, "R2 register select", hp_regsel, e.sel);
          chk(hp_half == e.half, "R2 byte identify", hp_half, e.half);
          chk(hp_data == e.data, "R2 data", hp_data, e.data);
          chk(cyc == e.due, "R6 strobe fall cycle", cyc, e.due);
          chk({m_prev_sel, m_prev_half, m_prev_data} == {hp_regsel, hp_half, hp_data},
              "R7 setup before fall", {m_prev_sel, m_prev_half, m_prev_data},
              {hp_regsel, hp_half, hp_data});
        end
      end else if (!hp_strobe_n) begin
        m_low++;
      end else if (!m_prev_strobe && hp_strobe_n) begin
        chk(m_low == WIDTH, "R6 strobe width", m_low, WIDTH);
        m_rise_val = {hp_regsel, hp_half, hp_data};
        m_hold_chk = 1'b1;
      end
      m_prev_strobe = hp_strobe_n;
      m_prev_sel    = hp_regsel;
      m_prev_half   = hp_half;
      m_prev_data   = hp_data;
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int f0;
    rst_n = 1'b0; isa_iow_n = 1'b1; isa_aen = 1'b0; isa_addr = '0; isa_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and tie-offs
    chk(hp_strobe_n == 1'b1, "R1 strobe idle", hp_strobe_n, 1);
    chk(dsp_rst_n == 1'b0, "R1 dsp held", dsp_rst_n, 0);
    chk({hp_regsel, hp_half, hp_data} == 11'd0, "R1 controls zero",
        {hp_regsel, hp_half, hp_data}, 0);
    chk({hp_rw, hp_as_n, hp_cs_n, hp_strobe_alt_n} == 4'b0101, "R1 tie-offs",
        {hp_rw, hp_as_n, hp_cs_n, hp_strobe_alt_n}, 4'b0101);

    // R9 release
    isa_write(10'h240, 8'h01, 1'b0, 6, 1'b0);
    chk(dsp_rst_n == 1'b1, "R9 release", dsp_rst_n, 1);

    // R2 all six window ports
    isa_write(10'h230, 8'h00, 1'b0, 6, 1'b1);
    isa_write(10'h231, 8'h12, 1'b0, 6, 1'b1);
    isa_write(10'h234, 8'h00, 1'b0, 6, 1'b1);
    isa_write(10'h235, 8'h80, 1'b0, 6, 1'b1);
    isa_write(10'h236, 8'hA5, 1'b0, 6, 1'b1);
    isa_write(10'h237, 8'h3C, 1'b0, 5, 1'b1);
    chk(falls == 6, "R2 strobe count", falls, 6);
    chk(sb_q.size() == 0, "R2 all items seen", sb_q.size(), 0);

    // R3 reserved slot
    f0 = falls;
    isa_write(10'h232, 8'h55, 1'b0, 6, 1'b0);
    isa_write(10'h233, 8'hAA, 1'b0, 6, 1'b0);
    chk(falls == f0, "R3 reserved no strobe", falls, f0);

    // R4 AEN high
    isa_write(10'h236, 8'h77, 1'b1, 6, 1'b0);
    isa_write(10'h240, 8'h00, 1'b1, 6, 1'b0);
    chk(falls == f0, "R4 dma no strobe", falls, f0);
    chk(dsp_rst_n == 1'b1, "R4 dma reset kept", dsp_rst_n, 1);

    // R5 outside the window
    isa_write(10'h22F, 8'h11, 1'b0, 6, 1'b0);
    isa_write(10'h238, 8'h22, 1'b0, 6, 1'b0);
    isa_write(10'h241, 8'h00, 1'b0, 6, 1'b0);
    isa_write(10'h330, 8'h00, 1'b0, 6, 1'b0);
    isa_write(10'h340, 8'h00, 1'b0, 6, 1'b0);
    chk(falls == f0, "R5 outside no strobe", falls, f0);
    chk(dsp_rst_n == 1'b1, "R5 reset kept", dsp_rst_n, 1);

    // R8 long ISA strobe gives one pulse
    isa_write(10'h237, 8'h5A, 1'b0, 30, 1'b1);
    chk(falls == f0 + 1, "R8 single pulse", falls, f0 + 1);

    // R9 bit 0 only, kept across host-port writes
    isa_write(10'h240, 8'hFE, 1'b0, 6, 1'b0);
    chk(dsp_rst_n == 1'b0, "R9 hold with FE", dsp_rst_n, 0);
    chk(falls == f0 + 1, "R9 no strobe", falls, f0 + 1);
    isa_write(10'h240, 8'h03, 1'b0, 6, 1'b0);
    chk(dsp_rst_n == 1'b1, "R9 release with 03", dsp_rst_n, 1);
    isa_write(10'h234, 8'h00, 1'b0, 6, 1'b1);
    isa_write(10'h235, 8'h7F, 1'b0, 6, 1'b1);
    chk(dsp_rst_n == 1'b1, "R9 kept after host writes", dsp_rst_n, 1);
    chk(sb_q.size() == 0, "R2 queue drained", sb_q.size(), 0);

    finish_run();
  end

endmodule